// File: doc/BRIEF.md
# Event Record Ring Logger

This block keeps a circular log of fixed-size event records in system memory. Software gives it a base address and a size exponent. The log then holds 2^size records of `REC_BYTES` bytes each. Software also owns a head pointer, and the block owns a tail pointer. Both pointers are byte offsets from the base.

When the event source offers a record, the block decides whether to log it. If it logs the record, it issues one memory write of that record at base plus tail. When the memory side acknowledges the write, the tail moves forward one record and wraps at the end of the log.

Two status bits report what happened, and an interrupt request is raised for the interrupt formatter:
- bit 0 is the overflow flag.
- bit 1 is the record-logged flag.

Software reads records, moves the head, and clears the status bits by writing ones to them. Writing the base register relocates the log and restarts both pointers. That write has no effect while the record-logged flag is still set.

Top module: `elog_ring`

## Requirements
- R1: After reset, base, size, head, tail and both status bits are zero, `mem_req` and `irq_req` are low, and `evt_ready` is high.
- R2: A base write does all of the following in the next cycle, unless status bit 1 is set:
  - it stores the address with its low `BASE_ALIGN_LG` bits cleared;
  - it stores the size, clamped to `MAX_SIZE_LOG`;
  - it clears head and tail to 0.
  While status bit 1 is set, the whole base write is ignored.
- R3: A record is written when all of these hold: the record is accepted (`evt_valid` with `evt_ready`), logging is on, status bit 0 is clear, and the log is not full. The write raises `mem_req` with `mem_addr` = base + tail and `mem_data` = the record. The request stays held and stable until `mem_ack`, and `evt_ready` stays low meanwhile.
- R4: On the cycle of `mem_ack`, the tail becomes (tail + `REC_BYTES`) modulo (`REC_BYTES` << size).
- R5: The log is full when the next tail equals the head. A record accepted while the log is full is not written and the tail is unchanged. If `intr_en` is high, status bit 0 is set and an interrupt is requested.
- R6: Logging is on only when both `glob_en` and `log_en` are high. A record accepted while logging is off, or while status bit 0 is set, is dropped. Nothing is written and no pointer or status bit changes.
- R7: On the cycle of `mem_ack`, status bit 1 is set and an interrupt is requested, but only if `intr_en` is high. With `intr_en` low, the status bits are untouched.
- R8: `irq_req` rises in the cycle after any status set. It stays high until `irq_ack` is seen.
- R9: Writing a one to a bit of `sts_clr` clears that status bit. When the block sets a bit in the same cycle, the set wins.
- R10: A head write stores the value with its low log2(`REC_BYTES`) bits cleared, wrapped to the log size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_en | input | 1 | Global enable |
| log_en | input | 1 | Logging enable |
| intr_en | input | 1 | Interrupt enable for both status events |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_data | input | BASE_W | New base address |
| size_wr | input | SIZE_W | New size exponent (records = 2^size) |
| head_wr_en | input | 1 | Head register write strobe |
| head_wr_data | input | PTR_W | New head byte offset |
| sts_clr | input | 2 | Write-one-to-clear for status bits |
| evt_valid | input | 1 | Record offered |
| evt_data | input | REC_W | Record contents |
| evt_ready | output | 1 | Block can accept a record |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | BASE_W | Memory write byte address |
| mem_data | output | REC_W | Memory write data |
| mem_ack | input | 1 | Memory write done |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt request taken |
| base_q | output | BASE_W | Current aligned base |
| size_q | output | SIZE_W | Current size exponent |
| head_q | output | PTR_W | Head byte offset |
| tail_q | output | PTR_W | Tail byte offset |
| log_status | output | 2 | Bit 0 overflow, bit 1 record logged |

## Verification
Results fall due at three different times, and the bench samples each one at its own time.
- The overflow flag and a dropped record settle at the acceptance edge. Base, head and status writes take effect at the edge that ends their one-cycle strobe.
- For a record that is written, `mem_req` appears after the acceptance edge. The tail, status bit 1 and `irq_req` change only at the edge where `mem_ack` is sampled, and the bench acknowledges two cycles into each request.

The bench drives inputs and reads outputs on falling edges. Each event task returns only after `evt_ready` has come back and one more falling edge has passed, so every pointer and status check sees settled values. Memory writes are compared by a monitor against a queue of expected address and data pairs that the driver fills. Any write the queue does not expect counts as a mismatch, and so does any entry still left in the queue.

// File: rtl/elog_pkg.sv
// Shared types for the event record ring logger.
// Assumes: status bit positions are fixed and visible to software.
package elog_pkg;
    localparam int ST_OVF = 0;   // overflow flag position
    localparam int ST_EVT = 1;   // record-logged flag position

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_WRITE = 1'b1
    } eng_state_t;
endpackage

// File: rtl/elog_ptrs.sv
// Base, size, head and tail registers of the ring, plus the derived
// wrap mask, next tail and full flag.
// Assumes: REC_BYTES is a power of two and the base load has priority over
// head writes and tail advances in the same cycle.
module elog_ptrs #(
    parameter int BASE_W        = 64,
    parameter int REC_BYTES     = 16,
    parameter int MAX_SIZE_LOG  = 8,
    parameter int SIZE_W        = 4,
    parameter int BASE_ALIGN_LG = 12,
    parameter int PTR_W         = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [BASE_W-1:0] base_wr_data,
    input  logic [SIZE_W-1:0] size_wr,
    input  logic              head_wr_en,
    input  logic [PTR_W-1:0]  head_wr_data,
    input  logic              adv_en,
    input  logic [PTR_W-1:0]  adv_val,
    output logic [BASE_W-1:0] base_q,
    output logic [SIZE_W-1:0] size_q,
    output logic [PTR_W-1:0]  head_q,
    output logic [PTR_W-1:0]  tail_q,
    output logic [PTR_W-1:0]  next_tail,
    output logic              full
);
    localparam logic [PTR_W-1:0] REC_LOW = PTR_W'(REC_BYTES - 1);

    logic [SIZE_W-1:0] size_clamped;
    logic [PTR_W:0]    span_bytes;
    logic [PTR_W-1:0]  wrap_mask;
    logic [BASE_W-1:0] base_aligned;

    // Clamp the requested size exponent to the largest supported log.
    always_comb begin
        if (size_wr > SIZE_W'(MAX_SIZE_LOG)) size_clamped = SIZE_W'(MAX_SIZE_LOG);
        else                                 size_clamped = size_wr;
    end

    // Align the new base by clearing its low address bits.
    always_comb begin
        base_aligned = {base_wr_data[BASE_W-1:BASE_ALIGN_LG], BASE_ALIGN_LG'(0)};
    end

    // Log span in bytes and the modulo mask derived from it.
    always_comb begin
        span_bytes = (PTR_W+1)'(REC_BYTES) << size_q;
        wrap_mask  = PTR_W'(span_bytes - 1'b1);
    end

    // Next tail position and full detection against the head.
    always_comb begin
        next_tail = (tail_q + PTR_W'(REC_BYTES)) & wrap_mask;
        full      = (next_tail == head_q);
    end

    // Pointer and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else if (base_load) begin
            base_q <= base_aligned;
            size_q <= size_clamped;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (head_wr_en) head_q <= head_wr_data & wrap_mask & ~REC_LOW;
            if (adv_en)     tail_q <= adv_val;
        end
    end

    AST_TAIL_IN_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q & ~wrap_mask) == '0); // R4
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_en && !base_load) |=> $stable(tail_q)); // R5
    AST_HEAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q & REC_LOW) == '0); // R10
endmodule

// File: rtl/elog_engine.sv
// Accepts records, decides write / overflow / drop, and runs one memory
// write at a time until it is acknowledged.
// Assumes: mem_ack is only asserted while mem_req is high.
module elog_engine
    import elog_pkg::*;
#(
    parameter int BASE_W = 64,
    parameter int REC_W  = 128,
    parameter int PTR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [REC_W-1:0]  evt_data,
    output logic              evt_ready,
    input  logic              log_on,
    input  logic              intr_en,
    input  logic              ovf,
    input  logic              full,
    input  logic [BASE_W-1:0] base_q,
    input  logic [PTR_W-1:0]  tail_q,
    input  logic [PTR_W-1:0]  next_tail,
    input  logic              base_load,
    output logic              mem_req,
    output logic [BASE_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_data,
    input  logic              mem_ack,
    output logic              adv_en,
    output logic [PTR_W-1:0]  adv_val,
    output logic              set_ovf,
    output logic              set_evt
);
    eng_state_t state;
    logic       accept;
    logic       go_write;
    logic       cancel_adv;
    logic       done;

    // Classify an accepted record.
    always_comb begin
        evt_ready = (state == ENG_IDLE);
        accept    = evt_valid && evt_ready;
        go_write  = accept && log_on && !ovf && !full;
        set_ovf   = accept && log_on && !ovf && full && intr_en;
    end

    // Completion of the outstanding write.
    always_comb begin
        mem_req = (state == ENG_WRITE);
        done    = mem_req && mem_ack;
        adv_en  = done && !cancel_adv;
        set_evt = done && intr_en;
    end

    // Write state, captured address, data and next tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            mem_addr   <= '0;
            mem_data   <= '0;
            adv_val    <= '0;
            cancel_adv <= 1'b0;
        end else if (go_write) begin
            state      <= ENG_WRITE;
            mem_addr   <= base_q + BASE_W'(tail_q);
            mem_data   <= evt_data;
            adv_val    <= next_tail;
            cancel_adv <= 1'b0;
        end else if (state == ENG_WRITE) begin
            if (base_load) cancel_adv <= 1'b1;
            if (mem_ack)   state      <= ENG_IDLE;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R3
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (!log_on || ovf)) |=> !mem_req); // R6
    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full) |=> !mem_req); // R5
endmodule

// File: rtl/elog_status.sv
// Status flags with write-one-to-clear and the level interrupt request.
// Assumes: a hardware set in the same cycle as a clear takes precedence.
module elog_status
    import elog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ovf,
    input  logic       set_evt,
    input  logic [1:0] sts_clr,
    input  logic       irq_ack,
    output logic [1:0] status,
    output logic       irq_req
);
    logic [1:0] set_vec;

    // Gather hardware set requests by bit position.
    always_comb begin
        set_vec         = '0;
        set_vec[ST_OVF] = set_ovf;
        set_vec[ST_EVT] = set_evt;
    end

    // Status flags and pending interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= '0;
            irq_req <= 1'b0;
        end else begin
            status <= (status & ~sts_clr) | set_vec;
            if (|set_vec)     irq_req <= 1'b1;
            else if (irq_ack) irq_req <= 1'b0;
        end
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> status[ST_OVF]); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_OVF] && !sts_clr[ST_OVF]) |=> status[ST_OVF]); // R9
endmodule

// File: rtl/elog_ring.sv
// Top of the event record ring logger: ties the pointer registers, the
// write engine and the status flags together.
// Assumes: software does not reprogram the base while it expects a write
// in flight to advance the tail (such an advance is discarded).
module elog_ring
    import elog_pkg::*;
#(
    parameter int BASE_W        = 64,
    parameter int REC_BYTES     = 16,
    parameter int MAX_SIZE_LOG  = 8,
    parameter int SIZE_W        = 4,
    parameter int BASE_ALIGN_LG = 12,
    localparam int REC_W        = REC_BYTES * 8,
    localparam int PTR_W        = $clog2(REC_BYTES) + MAX_SIZE_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic              log_en,
    input  logic              intr_en,
    input  logic              base_wr_en,
    input  logic [BASE_W-1:0] base_wr_data,
    input  logic [SIZE_W-1:0] size_wr,
    input  logic              head_wr_en,
    input  logic [PTR_W-1:0]  head_wr_data,
    input  logic [1:0]        sts_clr,
    input  logic              evt_valid,
    input  logic [REC_W-1:0]  evt_data,
    output logic              evt_ready,
    output logic              mem_req,
    output logic [BASE_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_data,
    input  logic              mem_ack,
    output logic              irq_req,
    input  logic              irq_ack,
    output logic [BASE_W-1:0] base_q,
    output logic [SIZE_W-1:0] size_q,
    output logic [PTR_W-1:0]  head_q,
    output logic [PTR_W-1:0]  tail_q,
    output logic [1:0]        log_status
);
    logic             base_load;
    logic             log_on;
    logic [PTR_W-1:0] next_tail;
    logic             full;
    logic             adv_en;
    logic [PTR_W-1:0] adv_val;
    logic             set_ovf;
    logic             set_evt;

    // Base writes are locked out while a logged-record flag is pending.
    always_comb begin
        base_load = base_wr_en && !log_status[ST_EVT];
        log_on    = glob_en && log_en;
    end

    elog_ptrs #(
        .BASE_W(BASE_W), .REC_BYTES(REC_BYTES), .MAX_SIZE_LOG(MAX_SIZE_LOG),
        .SIZE_W(SIZE_W), .BASE_ALIGN_LG(BASE_ALIGN_LG), .PTR_W(PTR_W)
    ) u_ptrs (
        .clk(clk), .rst_n(rst_n), .base_load(base_load),
        .base_wr_data(base_wr_data), .size_wr(size_wr),
        .head_wr_en(head_wr_en), .head_wr_data(head_wr_data),
        .adv_en(adv_en), .adv_val(adv_val),
        .base_q(base_q), .size_q(size_q), .head_q(head_q), .tail_q(tail_q),
        .next_tail(next_tail), .full(full)
    );

    elog_engine #(
        .BASE_W(BASE_W), .REC_W(REC_W), .PTR_W(PTR_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_data(evt_data),
        .evt_ready(evt_ready), .log_on(log_on), .intr_en(intr_en),
        .ovf(log_status[ST_OVF]), .full(full), .base_q(base_q),
        .tail_q(tail_q), .next_tail(next_tail), .base_load(base_load),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ack(mem_ack), .adv_en(adv_en), .adv_val(adv_val),
        .set_ovf(set_ovf), .set_evt(set_evt)
    );

    elog_status u_status (
        .clk(clk), .rst_n(rst_n), .set_ovf(set_ovf), .set_evt(set_evt),
        .sts_clr(sts_clr), .irq_ack(irq_ack), .status(log_status),
        .irq_req(irq_req)
    );

    AST_BASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_en && log_status[ST_EVT]) |=> $stable(base_q)); // R2
endmodule

// File: tb/elog_ring_test.sv
// Scoreboard bench for elog_ring: the driver queues expected memory writes,
// the monitor answers each request and compares it with the queue head.
module elog_ring_test;
    localparam int BASE_W = 64;
    localparam int REC_W  = 128;
    localparam int PTR_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              glob_en = 1'b0, log_en = 1'b0, intr_en = 1'b0;
    logic              base_wr_en = 1'b0;
    logic [BASE_W-1:0] base_wr_data = '0;
    logic [3:0]        size_wr = '0;
    logic              head_wr_en = 1'b0;
    logic [PTR_W-1:0]  head_wr_data = '0;
    logic [1:0]        sts_clr = '0;
    logic              evt_valid = 1'b0;
    logic [REC_W-1:0]  evt_data = '0;
    logic              evt_ready, mem_req, mem_ack = 1'b0, irq_req, irq_ack = 1'b0;
    logic [BASE_W-1:0] mem_addr, base_q;
    logic [REC_W-1:0]  mem_data;
    logic [3:0]        size_q;
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [1:0]        log_status;

    int n_chk = 0;
    int n_bad = 0;
    logic [BASE_W+REC_W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    elog_ring uut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .log_en(log_en),
        .intr_en(intr_en), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .size_wr(size_wr), .head_wr_en(head_wr_en), .head_wr_data(head_wr_data),
        .sts_clr(sts_clr), .evt_valid(evt_valid), .evt_data(evt_data),
        .evt_ready(evt_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ack(mem_ack), .irq_req(irq_req),
        .irq_ack(irq_ack), .base_q(base_q), .size_q(size_q), .head_q(head_q),
        .tail_q(tail_q), .log_status(log_status)
    );

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [REC_W-1:0] rec(int i);
        return {4{32'hC0DE_0000 + 32'(i)}};
    endfunction

    // Offer one record; expected write (if any) goes onto the scoreboard.
    task automatic send_event(int i, bit wr, logic [BASE_W-1:0] addr, logic [1:0] clr);
        if (wr) exp_q.push_back({addr, rec(i)});
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        evt_valid = 1'b1; evt_data = rec(i); sts_clr = clr;
        @(negedge clk);
        evt_valid = 1'b0; sts_clr = '0;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_base(logic [BASE_W-1:0] b, logic [3:0] s);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b; size_wr = s;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    task automatic write_head(logic [PTR_W-1:0] h);
        @(negedge clk);
        head_wr_en = 1'b1; head_wr_data = h;
        @(negedge clk);
        head_wr_en = 1'b0;
    endtask

    task automatic clear_status(logic [1:0] c);
        @(negedge clk);
        sts_clr = c; irq_ack = 1'b1;
        @(negedge clk);
        sts_clr = '0; irq_ack = 1'b0;
    endtask

    // Monitor: acknowledge two cycles into each request and compare.
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (exp_q.size() == 0) begin
                        chk("R3/R6 unexpected write", {mem_addr, mem_data}, '0);
                    end else begin
                        logic [BASE_W+REC_W-1:0] e;
                        e = exp_q.pop_front();
                        chk("R3 write addr+data", {mem_addr, mem_data}, e);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    localparam logic [BASE_W-1:0] B1 = 64'h1234_5678_9ABC_D000;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 base", base_q, 0);
        chk("R1 tail", tail_q, 0);
        chk("R1 head", head_q, 0);
        chk("R1 status", log_status, 0);
        chk("R1 req/irq/ready", {mem_req, irq_req, evt_ready}, 3'b001);

        write_base(64'h1234_5678_9ABC_DFFF, 4'd2);
        chk("R2 base aligned", base_q, B1);
        chk("R2 size", size_q, 2);

        glob_en = 1'b1; log_en = 1'b1; intr_en = 1'b1;
        send_event(0, 1'b1, B1 + 0, 2'b00);
        chk("R4 tail step", tail_q, 16);
        chk("R7 evt bit", log_status, 2'b10);
        chk("R8 irq raised", irq_req, 1);
        repeat (3) @(negedge clk);
        chk("R8 irq held", irq_req, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R8 irq dropped", irq_req, 0);

        write_base(64'h9000, 4'd3);
        chk("R2 base locked", base_q, B1);
        chk("R2 tail kept when locked", tail_q, 16);

        send_event(1, 1'b1, B1 + 16, 2'b00);
        send_event(2, 1'b1, B1 + 32, 2'b00);
        chk("R4 tail 48", tail_q, 48);
        send_event(3, 1'b0, 0, 2'b00);
        chk("R5 full tail kept", tail_q, 48);
        chk("R5 overflow set", log_status, 2'b11);
        send_event(4, 1'b0, 0, 2'b00);
        chk("R6 drop on overflow", tail_q, 48);

        clear_status(2'b11);
        chk("R9 clear", log_status, 2'b00);
        write_head(12'd37);
        chk("R10 head aligned", head_q, 32);

        send_event(5, 1'b1, B1 + 48, 2'b00);
        chk("R4 wrap to 0", tail_q, 0);
        send_event(6, 1'b1, B1 + 0, 2'b00);
        chk("R4 tail 16", tail_q, 16);
        clear_status(2'b11);
        send_event(7, 1'b0, 0, 2'b01);
        chk("R9 set wins over clear", log_status, 2'b01);

        clear_status(2'b01);
        log_en = 1'b0;
        send_event(8, 1'b0, 0, 2'b00);
        chk("R6 log_en off", {tail_q, 2'(log_status)}, {12'd16, 2'b00});
        log_en = 1'b1; glob_en = 1'b0;
        send_event(9, 1'b0, 0, 2'b00);
        chk("R6 glob_en off", {tail_q, 2'(log_status)}, {12'd16, 2'b00});
        glob_en = 1'b1;

        intr_en = 1'b0;
        write_head(12'd48);
        send_event(10, 1'b1, B1 + 16, 2'b00);
        chk("R4 tail 32", tail_q, 32);
        chk("R7 no bit without intr", {irq_req, log_status}, 3'b000);

        write_base(64'h8000_0123, 4'd0);
        chk("R2 new base", base_q, 64'h8000_0000);
        chk("R2 ptrs cleared", {head_q, tail_q}, 0);
        send_event(11, 1'b0, 0, 2'b00);
        chk("R5 single-record full, no intr", log_status, 2'b00);
        intr_en = 1'b1;
        send_event(12, 1'b0, 0, 2'b00);
        chk("R5 single-record full, intr", {irq_req, log_status}, 3'b101);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule